// File: doc/BRIEF.md
# Mode-decoding word-wide memory model with identifier readout

This block is a synthesizable, clocked stand-in for a UV-erasable, 16-bit-wide programmable read-only memory. Testbenches use it in place of the real part. It takes the active-low chip select, output enable and program strobe, together with two out-of-band flags. One flag says that the programming supply is raised. The other says that address line 9 carries the high identification voltage. From these it works out the device mode, and it either drives the stored word onto the data bus or leaves the bus undriven.

The storage is a reduced-depth array whose depth is a parameter. It comes out of reset, or out of an erase request, with every bit set to one. A program operation can only clear bits: the addressed word becomes its old value ANDed with the bus data. With the identification flag set, the block returns two fixed 8-bit codes that each have odd parity. Analog access times are not modelled. Every result instead appears a fixed number of clock cycles, `LAT`, after the inputs that caused it.

The data bus is modelled as a value plus a drive flag. When the drive flag is low the bus is high-impedance, and the value port is forced to zero.

Top module: `eprom_model`

## Requirements
- R1: While reset is low, and after it is released, every word of the array holds all ones and `dq_drv` is low until a driving mode has been held for `LAT` cycles.
- R2: With `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `a9_hv`=0, the block drives the word stored at `addr` (`dq_drv`=1), whatever `pgm_n` is.
- R3: With `ce_n`=1 the bus is not driven, whatever `oe_n`, `pgm_n`, `vpp_hi` or `a9_hv` are. With `vpp_hi`=1 and `ce_n`=1, no word is written.
- R4: With `ce_n`=0 and `oe_n`=1, in any mode other than program, the bus is not driven.
- R5: With `vpp_hi`=1, `ce_n`=0, `pgm_n`=0 and `a9_hv`=0, every clock edge stores (old word AND `din`) at `addr`, and the bus is not driven.
- R6: Programming never sets a stored bit from 0 back to 1.
- R7: With `vpp_hi`=1, `ce_n`=0, `oe_n`=0 and `pgm_n`=1, the block drives the stored word at `addr`.
- R8: With `a9_hv`=1, `vpp_hi`=0, `pgm_n`=1, `ce_n`=0, `oe_n`=0 and `addr[AW-1:1]`=0, the bus carries 16'h0001 when `addr[0]`=0 and 16'h008C when `addr[0]`=1. Bits 15..8 are zero.
- R9: Each identifier byte on bits 7..0 has an odd number of ones, and bit 7 is its parity bit.
- R10: With `a9_hv`=1, any of `vpp_hi`=1, `pgm_n`=0 or a nonzero `addr[AW-1:1]` while `ce_n`=0 is illegal. The bus is then not driven and no word is written.
- R11: `erase`=1 at a clock edge sets every word to all ones. It wins over a program in the same cycle.
- R12: Inputs sampled at clock edge k appear on `dq_drv`/`dq_out` after edge k+`LAT`-1. An array write made at edge k is seen by reads sampled at edge k+1 or later.
- R13: Whenever `dq_drv` is 0, `dq_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Active-low synchronous reset; fills the array with ones and empties the output pipeline |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply raised |
| a9_hv | input | 1 | Identification voltage present on address line 9 |
| erase | input | 1 | Sets the whole array to all ones at the clock edge |
| addr | input | AW (10) | Word address |
| din | input | WIDTH (16) | Data to program |
| dq_out | output | WIDTH (16) | Data bus value; zero when not driven |
| dq_drv | output | 1 | Data bus driven; 0 means high-impedance |

## Verification
Every bus result, whether a driven word, an identifier code or high-impedance, is due after the `LAT`-th rising edge, counting the edge that sampled the inputs. A program or erase takes effect at its own edge and is visible to reads sampled one edge later. The bench keeps a behavioural model that pushes one expected bus state per edge into a queue. It compares the queue entry from `LAT`-1 edges earlier against the ports at every falling edge. Directed checks hold each stimulus for `LAT` edges before sampling. The latency check samples one edge early and expects the old state.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

   typedef enum logic [2:0] {
      MD_STANDBY = 3'd0,
      MD_INHIBIT = 3'd1,
      MD_DISABLE = 3'd2,
      MD_READ    = 3'd3,
      MD_VERIFY  = 3'd4,
      MD_PROGRAM = 3'd5,
      MD_IDENT   = 3'd6,
      MD_ILLEGAL = 3'd7
   } eprom_mode_e;

   typedef enum logic [1:0] {
      SRC_NONE  = 2'd0,
      SRC_CELL  = 2'd1,
      SRC_IDENT = 2'd2
   } bus_src_e;

   function automatic logic odd_parity8(input logic [7:0] b);
      return ^b;
   endfunction

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
   import eprom_pkg::*;
#(
   parameter int AW = 10
) (
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          pgm_n,
   input  logic          vpp_hi,
   input  logic          a9_hv,
   input  logic [AW-1:0] addr,
   output eprom_mode_e   mode,
   output bus_src_e      src,
   output logic          wr_en
);

   logic upper_clear;
   logic id_legal;

   assign upper_clear = (addr[AW-1:1] == '0);
   assign id_legal    = upper_clear && !vpp_hi && pgm_n;

   always_comb begin
      mode = MD_STANDBY;
      if (ce_n) begin
         mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
      end else if (a9_hv) begin
         if (!id_legal)   mode = MD_ILLEGAL;
         else if (oe_n)   mode = MD_DISABLE;
         else             mode = MD_IDENT;
      end else if (vpp_hi) begin
         if (!pgm_n)      mode = MD_PROGRAM;
         else if (!oe_n)  mode = MD_VERIFY;
         else             mode = MD_DISABLE;
      end else begin
         mode = oe_n ? MD_DISABLE : MD_READ;
      end
   end

   always_comb begin
      unique case (mode)
         MD_READ, MD_VERIFY: src = SRC_CELL;
         MD_IDENT:           src = SRC_IDENT;
         default:            src = SRC_NONE;
      endcase
   end

   assign wr_en = (mode == MD_PROGRAM);

endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 1024,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             erase,
   input  logic             wr_en,
   input  logic [AW-1:0]    addr,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] rd_q
);

   logic [WIDTH-1:0] cells [DEPTH];

   assign rd_q = cells[addr];

   always_ff @(posedge clk) begin
      if (!rst_n || erase) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
      end else if (wr_en) begin
         cells[addr] <= cells[addr] & din;
      end
   end

endmodule

// File: rtl/eprom_out_pipe.sv
module eprom_out_pipe #(
   parameter int WIDTH = 16,
   parameter int LAT   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             drv_in,
   input  logic [WIDTH-1:0] dat_in,
   output logic             drv_out,
   output logic [WIDTH-1:0] dat_out
);

   generate
      if (LAT == 1) begin : g_single
         logic             drv_r;
         logic [WIDTH-1:0] dat_r;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               drv_r <= 1'b0;
               dat_r <= '0;
            end else begin
               drv_r <= drv_in;
               dat_r <= drv_in ? dat_in : '0;
            end
         end
         assign drv_out = drv_r;
         assign dat_out = dat_r;
      end else begin : g_chain
         logic             drv_s [LAT];
         logic [WIDTH-1:0] dat_s [LAT];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               drv_s[0] <= 1'b0;
               dat_s[0] <= '0;
            end else begin
               drv_s[0] <= drv_in;
               dat_s[0] <= drv_in ? dat_in : '0;
            end
         end
         for (genvar s = 1; s < LAT; s++) begin : g_stage
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  drv_s[s] <= 1'b0;
                  dat_s[s] <= '0;
               end else begin
                  drv_s[s] <= drv_s[s-1];
                  dat_s[s] <= dat_s[s-1];
               end
            end
         end
         assign drv_out = drv_s[LAT-1];
         assign dat_out = dat_s[LAT-1];
      end
   endgenerate

endmodule

// File: rtl/eprom_model.sv
module eprom_model
   import eprom_pkg::*;
#(
   parameter int          WIDTH  = 16,
   parameter int          DEPTH  = 1024,
   parameter int          LAT    = 2,
   parameter logic [7:0]  MFR_ID = 8'h01,
   parameter logic [7:0]  DEV_ID = 8'h8C,
   localparam int         AW     = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce_n,
   input  logic             oe_n,
   input  logic             pgm_n,
   input  logic             vpp_hi,
   input  logic             a9_hv,
   input  logic             erase,
   input  logic [AW-1:0]    addr,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dq_out,
   output logic             dq_drv
);

   generate
      if (WIDTH < 8) begin : g_bad_width
         initial $error("eprom_model: WIDTH must be at least 8");
      end
      if (DEPTH < 4 || (1 << AW) != DEPTH) begin : g_bad_depth
         initial $error("eprom_model: DEPTH must be a power of two of at least 4");
      end
      if (LAT < 1) begin : g_bad_lat
         initial $error("eprom_model: LAT must be at least 1");
      end
      if (!odd_parity8(MFR_ID) || !odd_parity8(DEV_ID)) begin : g_bad_id
         initial $error("eprom_model: identifier codes need odd parity");
      end
   endgenerate

   eprom_mode_e      mode;
   bus_src_e         src;
   logic             wr_en;
   logic [WIDTH-1:0] cell_q;
   logic [WIDTH-1:0] id_word;
   logic [WIDTH-1:0] bus_next;
   logic             drv_next;

   eprom_mode_dec #(.AW(AW)) u_dec (
      .ce_n   (ce_n),
      .oe_n   (oe_n),
      .pgm_n  (pgm_n),
      .vpp_hi (vpp_hi),
      .a9_hv  (a9_hv),
      .addr   (addr),
      .mode   (mode),
      .src    (src),
      .wr_en  (wr_en)
   );

   eprom_cell_array #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_cells (
      .clk   (clk),
      .rst_n (rst_n),
      .erase (erase),
      .wr_en (wr_en),
      .addr  (addr),
      .din   (din),
      .rd_q  (cell_q)
   );

   generate
      if (WIDTH > 8) begin : g_id_wide
         assign id_word = {{(WIDTH-8){1'b0}}, (addr[0] ? DEV_ID : MFR_ID)};
      end else begin : g_id_byte
         assign id_word = addr[0] ? DEV_ID : MFR_ID;
      end
   endgenerate

   always_comb begin
      unique case (src)
         SRC_CELL:  bus_next = cell_q;
         SRC_IDENT: bus_next = id_word;
         default:   bus_next = '0;
      endcase
   end

   assign drv_next = (src != SRC_NONE);

   eprom_out_pipe #(.WIDTH(WIDTH), .LAT(LAT)) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .drv_in  (drv_next),
      .dat_in  (bus_next),
      .drv_out (dq_drv),
      .dat_out (dq_out)
   );

endmodule

// File: rtl/eprom_model_chk.sv
module eprom_model_chk #(
   parameter int WIDTH = 16,
   parameter int AW    = 10,
   parameter int LAT   = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ce_n,
   input logic             oe_n,
   input logic             pgm_n,
   input logic             vpp_hi,
   input logic             a9_hv,
   input logic             erase,
   input logic [AW-1:0]    addr,
   input logic [WIDTH-1:0] din,
   input logic [WIDTH-1:0] dq_out,
   input logic             dq_drv,
   input logic             wr_en,
   input logic [WIDTH-1:0] cell_q
);

   localparam int CW = $clog2(LAT + 1) + 1;

   logic c_sby, c_dis, c_prg, c_id;
   logic [CW-1:0] n_sby, n_dis, n_prg, n_id;

   assign c_sby = ce_n;
   assign c_dis = !ce_n && oe_n && pgm_n;
   assign c_prg = !ce_n && vpp_hi && !pgm_n && !a9_hv;
   assign c_id  = !ce_n && !oe_n && pgm_n && !vpp_hi && a9_hv && (addr[AW-1:1] == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         n_sby <= '0; n_dis <= '0; n_prg <= '0; n_id <= '0;
      end else begin
         n_sby <= !c_sby ? '0 : (n_sby >= CW'(LAT) ? n_sby : n_sby + 1'b1);
         n_dis <= !c_dis ? '0 : (n_dis >= CW'(LAT) ? n_dis : n_dis + 1'b1);
         n_prg <= !c_prg ? '0 : (n_prg >= CW'(LAT) ? n_prg : n_prg + 1'b1);
         n_id  <= !c_id  ? '0 : (n_id  >= CW'(LAT) ? n_id  : n_id  + 1'b1);
      end
   end

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !dq_drv);  // R1

   AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (n_sby >= CW'(LAT)) |-> !dq_drv);  // R3

   AST_DISABLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (n_dis >= CW'(LAT)) |-> !dq_drv);  // R4

   AST_PROGRAM_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (n_prg >= CW'(LAT)) |-> !dq_drv);  // R5

   AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_en) && !$past(erase) && $stable(addr))
      |-> (cell_q == ($past(cell_q) & $past(din))));  // R6

   AST_ID_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      (n_id >= CW'(LAT)) |-> (dq_drv && (^dq_out[7:0]) && (dq_out[WIDTH-1:8] == '0)));  // R9

   AST_ERASE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(erase)) |-> (cell_q == '1));  // R11

   AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_drv |-> (dq_out == '0));  // R13

endmodule

bind eprom_model eprom_model_chk #(.WIDTH(WIDTH), .AW(AW), .LAT(LAT)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .ce_n   (ce_n),
   .oe_n   (oe_n),
   .pgm_n  (pgm_n),
   .vpp_hi (vpp_hi),
   .a9_hv  (a9_hv),
   .erase  (erase),
   .addr   (addr),
   .din    (din),
   .dq_out (dq_out),
   .dq_drv (dq_drv),
   .wr_en  (wr_en),
   .cell_q (cell_q)
);

// File: tb/eprom_model_test.sv
`timescale 1ns/1ps
module eprom_model_test;

   localparam int WIDTH = 16;
   localparam int DEPTH = 1024;
   localparam int LAT   = 2;
   localparam int AW    = $clog2(DEPTH);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_hi = 1'b0, a9_hv = 1'b0, erase = 1'b0;
   logic [AW-1:0]    addr = '0;
   logic [WIDTH-1:0] din = '0;
   logic [WIDTH-1:0] dq_out;
   logic             dq_drv;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   eprom_model #(.WIDTH(WIDTH), .DEPTH(DEPTH), .LAT(LAT)) uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
      .vpp_hi(vpp_hi), .a9_hv(a9_hv), .erase(erase), .addr(addr), .din(din),
      .dq_out(dq_out), .dq_drv(dq_drv)
   );

   // behavioural reference: one expected bus state per edge
   logic [WIDTH-1:0] ref_mem [DEPTH];
   bit               q_drv [$];
   logic [WIDTH-1:0] q_dat [$];

   always @(posedge clk) begin
      bit e_drv;
      logic [WIDTH-1:0] e_dat;
      if (!rst_n) begin
         q_drv.delete(); q_dat.delete();
         for (int i = 0; i < DEPTH; i++) ref_mem[i] = '1;
      end else begin
         e_drv = 1'b0; e_dat = '0;
         if (!ce_n && !oe_n && pgm_n && a9_hv && !vpp_hi && (addr >> 1) == 0) begin
            e_drv = 1'b1; e_dat = addr[0] ? 16'h008C : 16'h0001;
         end else if (!ce_n && !oe_n && !a9_hv && (!vpp_hi || pgm_n)) begin
            e_drv = 1'b1; e_dat = ref_mem[addr];
         end
         q_drv.push_back(e_drv); q_dat.push_back(e_dat);
         if (q_drv.size() > LAT) begin
            void'(q_drv.pop_front()); void'(q_dat.pop_front());
         end
         if (erase) begin
            for (int i = 0; i < DEPTH; i++) ref_mem[i] = '1;
         end else if (!ce_n && vpp_hi && !pgm_n && !a9_hv) begin
            ref_mem[addr] = ref_mem[addr] & din;
         end
      end
   end

   // R12: per-cycle comparison against the reference
   always @(negedge clk) begin
      bit x_drv;
      logic [WIDTH-1:0] x_dat;
      if (rst_n && !done) begin
         x_drv = (q_drv.size() == LAT) ? q_drv[0] : 1'b0;
         x_dat = (q_drv.size() == LAT) ? q_dat[0] : '0;
         n_chk++;
         if (dq_drv !== x_drv || dq_out !== x_dat) begin
            n_fail++;
            $display("FAIL R12 per-cycle (%s): actual drv=%0b dq=%h expected drv=%0b dq=%h",
                     cur_req, dq_drv, dq_out, x_drv, x_dat);
         end
      end
   end

   task automatic apply(input string req, input bit c, input bit o, input bit p,
                        input bit v, input bit h, input int a,
                        input logic [WIDTH-1:0] d, input bit e);
      cur_req = req;
      ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; a9_hv = h;
      addr = AW'(a); din = d; erase = e;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input bit x_drv, input logic [WIDTH-1:0] x_dat);
      n_chk++;
      if (dq_drv !== x_drv || dq_out !== x_dat) begin
         n_fail++;
         $display("FAIL %s: actual drv=%0b dq=%h expected drv=%0b dq=%h",
                  req, dq_drv, dq_out, x_drv, x_dat);
      end
   endtask

   task automatic do_read(input string req, input int a, input logic [WIDTH-1:0] x);
      apply(req, 0, 0, 1, 0, 0, a, '0, 0);
      wait_cyc(LAT);
      chk(req, 1'b1, x);
   endtask

   task automatic do_prog(input string req, input int a, input logic [WIDTH-1:0] d);
      apply(req, 0, 1, 0, 1, 0, a, d, 0);
      wait_cyc(LAT);
      chk(req, 1'b0, '0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      wait_cyc(5);
      chk("R1 reset bus idle", 1'b0, '0);
      rst_n = 1'b1;
      wait_cyc(1);
      chk("R1 idle after reset", 1'b0, '0);
      do_read("R1 erased word", 5, 16'hFFFF);
      do_read("R2 read last erased word", DEPTH-1, 16'hFFFF);

      do_prog("R5 program bus idle", 5, 16'hA5C3);
      apply("R7 verify", 0, 0, 1, 1, 0, 5, '0, 0);
      wait_cyc(LAT);
      chk("R7 verify word", 1'b1, 16'hA5C3);
      do_read("R2 read programmed word", 5, 16'hA5C3);

      do_prog("R6 program ones", 5, 16'hFFFF);
      do_read("R6 ones do not set bits", 5, 16'hA5C3);
      do_prog("R6 program mask", 5, 16'h0FF0);
      do_read("R6 and of old and new", 5, 16'h05C0);
      do_prog("R5 program second word", 6, 16'h1234);
      do_read("R5 read second word", 6, 16'h1234);
      do_prog("R2 program top word", DEPTH-1, 16'h0000);
      do_read("R2 read top word", DEPTH-1, 16'h0000);

      apply("R3 standby oe low", 1, 0, 1, 0, 0, 6, '0, 0);
      wait_cyc(LAT);
      chk("R3 standby", 1'b0, '0);
      apply("R3 inhibit", 1, 0, 0, 1, 0, 7, 16'h0000, 0);
      wait_cyc(LAT);
      chk("R3 inhibit bus", 1'b0, '0);
      do_read("R3 inhibit wrote nothing", 7, 16'hFFFF);

      apply("R4 output disable", 0, 1, 1, 0, 0, 6, '0, 0);
      wait_cyc(LAT);
      chk("R4 disable", 1'b0, '0);
      apply("R4 verify disable", 0, 1, 1, 1, 0, 6, '0, 0);
      wait_cyc(LAT);
      chk("R4 disable with supply", 1'b0, '0);

      apply("R8 maker code", 0, 0, 1, 0, 1, 0, '0, 0);
      wait_cyc(LAT);
      chk("R8 maker code", 1'b1, 16'h0001);
      chk("R9 maker parity", 1'b1, {8'h00, dq_out[7:0]});
      n_chk++;
      if (^dq_out[7:0] !== 1'b1) begin
         n_fail++;
         $display("FAIL R9 maker parity: actual=%0b expected=1", ^dq_out[7:0]);
      end
      apply("R8 device code", 0, 0, 1, 0, 1, 1, '0, 0);
      wait_cyc(LAT);
      chk("R8 device code", 1'b1, 16'h008C);
      n_chk++;
      if (^dq_out[7:0] !== 1'b1) begin
         n_fail++;
         $display("FAIL R9 device parity: actual=%0b expected=1", ^dq_out[7:0]);
      end

      apply("R10 upper address set", 0, 0, 1, 0, 1, 2, '0, 0);
      wait_cyc(LAT);
      chk("R10 upper address", 1'b0, '0);
      apply("R10 flag with program", 0, 0, 0, 1, 1, 0, 16'h0000, 0);
      wait_cyc(LAT);
      chk("R10 flag with program", 1'b0, '0);
      do_read("R10 no write", 0, 16'hFFFF);

      apply("R12 latency", 1, 1, 1, 0, 0, 6, '0, 0);
      wait_cyc(LAT);
      apply("R12 latency", 0, 0, 1, 0, 0, 6, '0, 0);
      if (LAT > 1) begin
         wait_cyc(LAT - 1);
         chk("R12 not yet driven", 1'b0, '0);
         wait_cyc(1);
      end else begin
         wait_cyc(1);
      end
      chk("R12 driven on time", 1'b1, 16'h1234);

      apply("R11 erase beats program", 0, 1, 0, 1, 0, 8, 16'h0000, 1);
      wait_cyc(1);
      apply("R11 erase", 1, 1, 1, 0, 0, 0, '0, 0);
      wait_cyc(1);
      do_read("R11 erased word", 6, 16'hFFFF);
      do_read("R11 program lost", 8, 16'hFFFF);
      do_read("R11 top word erased", DEPTH-1, 16'hFFFF);

      apply("R13 idle", 1, 1, 1, 0, 0, 0, '0, 0);
      wait_cyc(LAT);
      chk("R13 idle bus zero", 1'b0, '0);
      finish_run();
   end

endmodule